// File: doc/BRIEF.md
# Paletted Texel Fetch Unit

The unit turns one logical texture coordinate (u, v) into the 16-bit 5:5:5 colour word for that texel. It reads a 1024 x 512 halfword frame memory through a synchronous read port. The unit drives a one-cycle read strobe with a column and a row, and the memory returns the word on the following cycle. The current texture page gives a base cell and a colour depth. A separate 15-bit palette locator says where the colour table sits in frame memory.

At the two indexed depths, one frame-memory pixel packs several texels. The unit first reads the packed pixel and extracts the index for the requested u. It then makes a second, dependent read into the palette row, and that palette word is the result. At the direct depth, the single pixel read is already the result.

Requests use a ready/valid handshake. Only one request is in flight at a time. The result appears on a one-cycle valid pulse.

Top module: `texel_fetch_unit`

## Requirements
- R1: After reset, `req_ready` is 1, `tex_valid` is 0 and `mem_rd_en` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. From the cycle after acceptance, `req_ready` stays 0 until the result is presented. `tex_valid` is a single-cycle pulse, and `req_ready` is 1 in that same cycle. A `req_valid` held high while the unit is busy has no effect on the result.
- R3: The page base column is `page_x * 64`. The page base row is `page_y * 256`. At every depth the texel row is base row + v.
- R4: At depth code 0 (4-bit indexed), the texel pixel is at column base + (u >> 2). The index is bits [4k+3:4k] of that pixel, where k = u[1:0]. The result is the frame-memory word at (palette column + index, palette row).
- R5: At depth code 1 (8-bit indexed), the texel pixel is at column base + (u >> 1). The index is bits [7:0] of that pixel for even u and bits [15:8] for odd u. The palette read works as in R4, with up to 256 entries on one row.
- R6: At depth code 2 (direct), the result is the pixel at (base + u, base row + v). The palette locator is ignored.
- R7: Depth code 3 behaves exactly like depth code 2.
- R8: Palette locator bits [5:0] times 16 give the palette column. Bits [14:6] give the palette row.
- R9: Column sums wrap modulo 1024 and row sums wrap modulo 512.
- R10: `tex_valid` rises 2 clock edges after the accepting edge for direct depths, and 4 edges after it for indexed depths.
- R11: Each `mem_rd_en` strobe lasts one cycle and occurs only while the unit is busy. A direct request makes one read and an indexed request makes two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to accept |
| req_u | input | 8 | Logical texture column |
| req_v | input | 8 | Logical texture row |
| page_x | input | 4 | Page base cell column (units of 64) |
| page_y | input | 1 | Page base cell row (units of 256) |
| depth | input | 2 | 0 = 4-bit, 1 = 8-bit, 2/3 = direct |
| pal_loc | input | 15 | Palette locator: [5:0] column/16, [14:6] row |
| mem_rd_en | output | 1 | Frame-memory read strobe |
| mem_rd_x | output | 10 | Frame-memory read column |
| mem_rd_y | output | 9 | Frame-memory read row |
| mem_rd_data | input | 16 | Read data, valid the cycle after the strobe |
| tex_valid | output | 1 | Result valid pulse |
| tex_data | output | 16 | Resulting 5:5:5 texel word |

## Verification
The hardest case to reach is the dependent second read. Its address comes from data the memory itself returned, so a wrong nibble or byte lane only shows up if that lane carries a distinct value. The bench memory therefore returns a hash of each address. The expected texel is then a two-level function of (u, v, page, locator), and every lane and every palette offset gives a different colour. To reach the column wrap, palette locators are pushed to column cell 63 with high 8-bit indexes, and direct fetches use page cell 15 with large u. A spurious request is raised while the unit is busy so that the ignore path is exercised.

// File: rtl/tfu_pkg.sv
package tfu_pkg;
  typedef enum logic [1:0] {
    DEPTH_IDX4  = 2'd0,
    DEPTH_IDX8  = 2'd1,
    DEPTH_DIR   = 2'd2,
    DEPTH_DIR_B = 2'd3
  } depth_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TEX_RD,
    ST_TEX_WAIT,
    ST_PAL_RD,
    ST_PAL_WAIT
  } fsm_e;

  function automatic logic is_direct(input logic [1:0] d);
    return d[1];
  endfunction
endpackage

// File: rtl/tfu_texel_addr.sv
module tfu_texel_addr #(
  parameter int UV_W     = 8,
  parameter int X_W      = 10,
  parameter int Y_W      = 9,
  parameter int PGX_W    = 4,
  parameter int PGX_SHFT = 6,
  parameter int PGY_SHFT = 8
) (
  input  logic [UV_W-1:0]  u,
  input  logic [UV_W-1:0]  v,
  input  logic [PGX_W-1:0] page_x,
  input  logic             page_y,
  input  logic [1:0]       depth,
  output logic [X_W-1:0]   col,
  output logic [Y_W-1:0]   row
);
  import tfu_pkg::*;
  logic [X_W-1:0] base_x, u_ext, u_off;
  logic [Y_W-1:0] base_y;

  always_comb begin
    base_x = X_W'(page_x) << PGX_SHFT;
    base_y = Y_W'(page_y) << PGY_SHFT;
    u_ext  = X_W'(u);
    case (depth)
      DEPTH_IDX4: u_off = u_ext >> 2;
      DEPTH_IDX8: u_off = u_ext >> 1;
      default:    u_off = u_ext;
    endcase
    col = base_x + u_off;
    row = base_y + Y_W'(v);
  end
endmodule

// File: rtl/tfu_index_extract.sv
module tfu_index_extract #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 8
) (
  input  logic [DATA_W-1:0] pixel,
  input  logic [1:0]        lane,
  input  logic [1:0]        depth,
  output logic [IDX_W-1:0]  index
);
  import tfu_pkg::*;
  localparam int NIB_N  = DATA_W / 4;
  localparam int BYTE_N = DATA_W / 8;

  logic [3:0] nib  [NIB_N];
  logic [7:0] byte_l [BYTE_N];

  for (genvar g = 0; g < NIB_N; g++) begin : g_nib
    assign nib[g] = pixel[4*g +: 4];
  end
  for (genvar g = 0; g < BYTE_N; g++) begin : g_byte
    assign byte_l[g] = pixel[8*g +: 8];
  end

  always_comb begin
    if (depth == DEPTH_IDX4) index = IDX_W'(nib[lane]);
    else                     index = IDX_W'(byte_l[lane[0]]);
  end
endmodule

// File: rtl/tfu_palette_addr.sv
module tfu_palette_addr #(
  parameter int X_W   = 10,
  parameter int Y_W   = 9,
  parameter int IDX_W = 8,
  parameter int PCX_W = 6,
  parameter int LOC_W = PCX_W + Y_W
) (
  input  logic [LOC_W-1:0] loc,
  input  logic [IDX_W-1:0] index,
  output logic [X_W-1:0]   col,
  output logic [Y_W-1:0]   row
);
  always_comb begin
    col = (X_W'(loc[PCX_W-1:0]) << 4) + X_W'(index);
    row = loc[LOC_W-1:PCX_W];
  end
endmodule

// File: rtl/texel_fetch_unit.sv
module texel_fetch_unit #(
  parameter int UV_W   = 8,
  parameter int X_W    = 10,
  parameter int Y_W    = 9,
  parameter int DATA_W = 16,
  parameter int PGX_W  = 4,
  parameter int PCX_W  = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [UV_W-1:0]        req_u,
  input  logic [UV_W-1:0]        req_v,
  input  logic [PGX_W-1:0]       page_x,
  input  logic                   page_y,
  input  logic [1:0]             depth,
  input  logic [PCX_W+Y_W-1:0]   pal_loc,
  output logic                   mem_rd_en,
  output logic [X_W-1:0]         mem_rd_x,
  output logic [Y_W-1:0]         mem_rd_y,
  input  logic [DATA_W-1:0]      mem_rd_data,
  output logic                   tex_valid,
  output logic [DATA_W-1:0]      tex_data
);
  import tfu_pkg::*;
  localparam int LOC_W = PCX_W + Y_W;
  localparam int IDX_W = 8;

  fsm_e               state;
  logic [1:0]         lane_q, depth_q;
  logic [LOC_W-1:0]   loc_q;
  logic [X_W-1:0]     tcol, pcol;
  logic [Y_W-1:0]     trow, prow;
  logic [IDX_W-1:0]   index;
  logic               accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  tfu_texel_addr #(.UV_W(UV_W), .X_W(X_W), .Y_W(Y_W), .PGX_W(PGX_W)) u_taddr (
    .u(req_u), .v(req_v), .page_x(page_x), .page_y(page_y), .depth(depth),
    .col(tcol), .row(trow));

  tfu_index_extract #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_idx (
    .pixel(mem_rd_data), .lane(lane_q), .depth(depth_q), .index(index));

  tfu_palette_addr #(.X_W(X_W), .Y_W(Y_W), .IDX_W(IDX_W), .PCX_W(PCX_W)) u_paddr (
    .loc(loc_q), .index(index), .col(pcol), .row(prow));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_rd_en <= 1'b0;
      mem_rd_x  <= '0;
      mem_rd_y  <= '0;
      tex_valid <= 1'b0;
      tex_data  <= '0;
      lane_q    <= '0;
      depth_q   <= '0;
      loc_q     <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      tex_valid <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          lane_q    <= req_u[1:0];
          depth_q   <= depth;
          loc_q     <= pal_loc;
          mem_rd_en <= 1'b1;
          mem_rd_x  <= tcol;
          mem_rd_y  <= trow;
          state     <= ST_TEX_RD;
        end
        ST_TEX_RD: state <= ST_TEX_WAIT;
        ST_TEX_WAIT: begin
          if (is_direct(depth_q)) begin
            tex_data  <= mem_rd_data;
            tex_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            mem_rd_en <= 1'b1;
            mem_rd_x  <= pcol;
            mem_rd_y  <= prow;
            state     <= ST_PAL_RD;
          end
        end
        ST_PAL_RD: state <= ST_PAL_WAIT;
        ST_PAL_WAIT: begin
          tex_data  <= mem_rd_data;
          tex_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  rd_strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);
  // R11
  rd_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);
  // R2
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tex_valid |=> !tex_valid);
  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R2
  valid_with_ready_chk: assert property (@(posedge clk) disable iff (rst)
    tex_valid |-> req_ready);
  // R10
  direct_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TEX_WAIT && is_direct(depth_q)) |=> tex_valid);
endmodule

// File: tb/texel_fetch_unit_tb.sv
module texel_fetch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_u = '0, req_v = '0;
  logic [3:0]  page_x = '0;
  logic        page_y = 1'b0;
  logic [1:0]  depth = '0;
  logic [14:0] pal_loc = '0;
  logic        mem_rd_en;
  logic [9:0]  mem_rd_x;
  logic [8:0]  mem_rd_y;
  logic [15:0] mem_rd_data = '0;
  logic        tex_valid;
  logic [15:0] tex_data;

  always #2 clk = ~clk;

  texel_fetch_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_u(req_u), .req_v(req_v), .page_x(page_x), .page_y(page_y),
    .depth(depth), .pal_loc(pal_loc), .mem_rd_en(mem_rd_en),
    .mem_rd_x(mem_rd_x), .mem_rd_y(mem_rd_y), .mem_rd_data(mem_rd_data),
    .tex_valid(tex_valid), .tex_data(tex_data));

  typedef struct {
    logic [15:0] data;
    int          reads;
    int          acc_edge;
    int          lat;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int n_cmp = 0, n_bad = 0, cyc = 0, rd_cnt = 0, rd_base = 0;

  function automatic logic [15:0] mem_fn(input logic [9:0] x, input logic [8:0] y);
    logic [31:0] t;
    t = (32'(x) * 32'd40503) ^ (32'(y) * 32'd7919) ^ 32'h0000A5C3;
    return t[15:0] ^ t[31:16];
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) begin
      mem_rd_data <= mem_fn(mem_rd_x, mem_rd_y);
      rd_cnt      <= rd_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [7:0] u, input logic [7:0] v,
      input logic [3:0] px, input logic py, input logic [1:0] d, input logic [14:0] pl);
    logic [9:0] bx, col;
    logic [8:0] row;
    logic [15:0] pix;
    logic [7:0] idx;
    bx  = 10'(px) * 10'd64;
    row = 9'(py) * 9'd256 + 9'(v);
    if (d == 2'd0) begin
      col = bx + 10'(u >> 2);
      pix = mem_fn(col, row);
      idx = 8'((pix >> (4 * u[1:0])) & 16'hF);
    end else if (d == 2'd1) begin
      col = bx + 10'(u >> 1);
      pix = mem_fn(col, row);
      idx = u[0] ? pix[15:8] : pix[7:0];
    end else begin
      return mem_fn(bx + 10'(u), row);
    end
    return mem_fn(10'(pl[5:0]) * 10'd16 + 10'(idx), pl[14:6]);
  endfunction

  task automatic send(input logic [7:0] u, input logic [7:0] v, input logic [3:0] px,
      input logic py, input logic [1:0] d, input logic [14:0] pl,
      input string tag, input bit poke);
    exp_t e;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_u = u; req_v = v; page_x = px; page_y = py; depth = d; pal_loc = pl;
    req_valid = 1'b1;
    e.data = model(u, v, px, py, d, pl);
    e.reads = d[1] ? 1 : 2;
    e.lat = d[1] ? 2 : 4;
    e.acc_edge = cyc + 1;
    e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    if (poke) begin
      // R2: busy request with different fields must be ignored
      req_u = ~u; req_v = ~v; page_x = ~px; depth = ~d; pal_loc = ~pl;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && tex_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected valid", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check({e.tag, " data"}, tex_data, e.data);
        check("R10 latency", cyc - e.acc_edge, e.lat);
        check("R11 read count", rd_cnt - rd_base, e.reads);
        check("R2 ready with valid", req_ready, 1);
        rd_base = rd_cnt;
      end
    end
  end

  initial begin
    #400000;
    check("watchdog", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 valid", tex_valid, 0);
    check("R1 rd_en", mem_rd_en, 0);
    // R4 4-bit lanes, R3 page base, R8 locator
    for (int k = 0; k < 4; k++)
      send(8'(k + 4), 8'd3, 4'd8, 1'b0, 2'd0, {9'd256, 6'd32}, "R4 idx4 lane", 1'b0);
    send(8'd255, 8'd200, 4'd2, 1'b1, 2'd0, {9'd17, 6'd5}, "R3 idx4 page_y", 1'b1);
    // R5 8-bit lanes
    send(8'd10, 8'd0, 4'd9, 1'b0, 2'd1, {9'd257, 6'd32}, "R5 idx8 even", 1'b0);
    send(8'd11, 8'd7, 4'd9, 1'b0, 2'd1, {9'd257, 6'd32}, "R5 idx8 odd", 1'b1);
    // R9 palette column wrap
    send(8'd77, 8'd9, 4'd3, 1'b1, 2'd1, {9'd500, 6'd63}, "R9 palette wrap", 1'b0);
    // R6 direct, locator ignored
    send(8'd5, 8'd6, 4'd10, 1'b0, 2'd2, 15'h7FFF, "R6 direct", 1'b1);
    send(8'd5, 8'd6, 4'd10, 1'b0, 2'd2, 15'h0000, "R6 direct loc0", 1'b0);
    // R9 direct column wrap
    send(8'd200, 8'd255, 4'd15, 1'b1, 2'd2, 15'h0123, "R9 direct wrap", 1'b0);
    // R7 depth 3
    send(8'd33, 8'd44, 4'd10, 1'b0, 2'd3, 15'h1111, "R7 depth3", 1'b1);
    for (int k = 0; k < 60; k++)
      send(8'($urandom), 8'($urandom), 4'($urandom), 1'($urandom), 2'($urandom),
           15'($urandom), "R3 random", 1'($urandom));
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R2 idle ready", req_ready, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule